// File: doc/BRIEF.md
# SPI Burst Register Access Slave

This block is an SPI slave (mode 0, 8-bit framing) that turns host transactions into 32-bit word reads and writes on an internal register/RAM bus with a 16-bit byte address. Every transaction starts with a four-byte header. The header carries an opcode, the high address byte, the low address byte and a word count, in that order. A burst of words follows, and the internal address advances by one word per transfer. Words cross the wire big-endian.

On MISO the slave first returns a one-byte global status. On a read, the three bytes after the status are zero padding, and read data begins at byte four. Framing problems are reported as single-cycle event pulses: an unknown opcode, a transfer cut short, excess clocks, and a chip-select edge that splits a byte. The block runs on a fast system clock. The SPI pins are sampled as synchronous inputs, and each SCLK phase must last at least three system clocks.

Top module: `spi_burst_slave`

## Requirements
- R1: Opcode 0x61 starts a burst write and 0x41 a burst read. Any other first byte pulses `ev_cmd_o` once when that byte completes. After that, the rest of the transaction makes no bus access, raises no underflow or overflow event, and returns zero bytes on MISO.
- R2: Header byte 1 is address bits 15:8, byte 2 is address bits 7:0, and byte 3 is the word count. A count of 0 means 256 words. The address advances by 4 per word and wraps within 16 bits.
- R3: Write data bytes are assembled most significant byte first. A word is committed by a one-cycle `bus_wr_o` pulse only after its fourth byte is complete, with `bus_addr_o` and `bus_wdata_o` valid in the same cycle.
- R4: A read issues a one-cycle `bus_rd_o` pulse when the header completes, and another pulse as each word except the last completes. `bus_rdata_i` is taken the cycle after the pulse. Bytes 1 to 3 on MISO are zero, and data words follow from byte 4, most significant byte first.
- R5: Byte 0 on MISO is `status_i` with bit 3 replaced by an error flag. That flag is 1 if the previous transaction raised any event and 0 otherwise.
- R6: Chip select rising with a valid opcode, before the header or the declared number of words is complete, pulses `ev_under_o` once. Words already completed stay committed.
- R7: The first SCLK rise after the last declared word pulses `ev_over_o` once. Later clocks cause no bus access, and the bytes clocked out on MISO after the burst are zero.
- R8: Chip select rising when the number of SCLK rises is not a multiple of 8 pulses `ev_end_o` once.
- R9: SPI mode 0 is used. MOSI is sampled on SCLK rise and MISO changes on SCLK fall. The first status bit is valid from the chip-select fall.
- R10: While `rst_ni` is low, all strobes, events and `miso_o` are 0. The status error flag resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | SPI clock, synchronous to clk_i |
| cs_ni | input | 1 | SPI chip select, active low |
| mosi_i | input | 1 | Serial data from host |
| miso_o | output | 1 | Serial data to host, 0 when deselected |
| status_i | input | 8 | Status bits returned in byte 0 (bit 3 replaced) |
| bus_addr_o | output | 16 | Internal byte address |
| bus_wr_o | output | 1 | Write strobe, one cycle |
| bus_wdata_o | output | 32 | Write data |
| bus_rd_o | output | 1 | Read strobe, one cycle |
| bus_rdata_i | input | 32 | Read data, valid the cycle after bus_rd_o |
| ev_cmd_o | output | 1 | Invalid-opcode event pulse |
| ev_under_o | output | 1 | Short-transfer event pulse |
| ev_over_o | output | 1 | Excess-clock event pulse |
| ev_end_o | output | 1 | Chip select off a byte boundary event pulse |

## Verification
The bench builds the block with its default opcodes and the byte-wide count field. With these values a zero count yields the full 256-word burst, and the run includes that burst starting near the top of the 16-bit address space, so the wrap is covered. SCLK phases of four system clocks exercise the rule that a read word is fetched before its first bit leaves, with little slack left. Short, long, misaligned and invalid frames are mixed between good ones, so the carried status error flag is seen in both states.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
  localparam int BYTE_W  = 8;
  localparam int ADDR_W  = 16;
  localparam int WORD_W  = 32;
  localparam int BPW     = WORD_W / BYTE_W;
  localparam int BIT_W   = $clog2(BYTE_W);
  localparam int WB_W    = $clog2(BPW);
  localparam int ERR_BIT = 3;

  typedef enum logic [2:0] {
    PH_OP,
    PH_HDR,
    PH_DATA,
    PH_DONE,
    PH_IGN
  } phase_e;
endpackage

// File: rtl/sbr_edges.sv
module sbr_edges (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic cs_ni,
  output logic sclk_rise_o,
  output logic sclk_fall_o,
  output logic cs_fall_o,
  output logic cs_rise_o
);
  logic sclk_q, cs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
    end else begin
      sclk_q <= sclk_i;
      cs_q   <= cs_ni;
    end
  end

  assign sclk_rise_o = sclk_i & ~sclk_q & ~cs_ni;
  assign sclk_fall_o = ~sclk_i & sclk_q & ~cs_ni;
  assign cs_fall_o   = cs_q & ~cs_ni;
  assign cs_rise_o   = ~cs_q & cs_ni;
endmodule

// File: rtl/sbr_rx.sv
module sbr_rx #(
  parameter int W  = 8,
  localparam int CW = $clog2(W)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          shift_i,
  input  logic          bit_i,
  output logic [CW-1:0] cnt_o,
  output logic          done_o,
  output logic [W-1:0]  byte_o
);
  logic [W-2:0]  sr;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr  <= '0;
      cnt <= '0;
    end else if (clr_i) begin
      cnt <= '0;
    end else if (shift_i) begin
      sr  <= {sr[W-3:0], bit_i};
      cnt <= cnt + 1'b1;
    end
  end

  assign cnt_o  = cnt;
  assign done_o = shift_i && (cnt == CW'(W - 1));
  assign byte_o = {sr, bit_i};
endmodule

// File: rtl/sbr_tx.sv
module sbr_tx #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] din_i,
  input  logic         shift_i,
  output logic         bit_o
);
  logic [W-1:0] sr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr <= '0;
    else if (load_i)  sr <= din_i;
    else if (shift_i) sr <= {sr[W-2:0], 1'b0};
  end

  assign bit_o = sr[W-1];
endmodule

// File: rtl/spi_burst_slave.sv
module spi_burst_slave
  import sbr_pkg::*;
#(
  parameter logic [BYTE_W-1:0] OPC_WR = 8'h61,
  parameter logic [BYTE_W-1:0] OPC_RD = 8'h41
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              cs_ni,
  input  logic              mosi_i,
  output logic              miso_o,
  input  logic [BYTE_W-1:0] status_i,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              bus_wr_o,
  output logic [WORD_W-1:0] bus_wdata_o,
  output logic              bus_rd_o,
  input  logic [WORD_W-1:0] bus_rdata_i,
  output logic              ev_cmd_o,
  output logic              ev_under_o,
  output logic              ev_over_o,
  output logic              ev_end_o
);
  localparam int MAX_WORDS = 1 << BYTE_W;
  localparam int TOT_W     = BYTE_W + 1;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(BPW);

  logic sclk_rise, sclk_fall, cs_fall, cs_rise;
  logic [BIT_W-1:0]  bit_cnt;
  logic              byte_done;
  logic [BYTE_W-1:0] rx_byte;
  logic              tx_bit, tx_load;
  logic [BYTE_W-1:0] tx_din, stat_byte, next_byte;

  phase_e            phase;
  logic [1:0]        hdr_idx;
  logic              op_rd;
  logic [ADDR_W-1:0] addr_q;
  logic [TOT_W-1:0]  total_q, done_q, done_n;
  logic [WB_W-1:0]   wb_idx;
  logic [WORD_W-1:0] wr_sr, rd_word;
  logic              rd_pend, txn_err, err_prev, rd_shift;

  sbr_edges u_edges (
    .clk_i, .rst_ni, .sclk_i, .cs_ni,
    .sclk_rise_o(sclk_rise), .sclk_fall_o(sclk_fall),
    .cs_fall_o(cs_fall), .cs_rise_o(cs_rise)
  );

  sbr_rx #(.W(BYTE_W)) u_rx (
    .clk_i, .rst_ni, .clr_i(cs_fall | cs_rise), .shift_i(sclk_rise), .bit_i(mosi_i),
    .cnt_o(bit_cnt), .done_o(byte_done), .byte_o(rx_byte)
  );

  always_comb begin
    stat_byte          = status_i;
    stat_byte[ERR_BIT] = err_prev;
  end

  // a new byte starts on the fall that follows a completed byte
  assign rd_shift  = sclk_fall && (bit_cnt == '0) && (phase == PH_DATA) && op_rd;
  assign next_byte = rd_shift ? rd_word[WORD_W-1 -: BYTE_W] : '0;
  assign tx_load   = cs_fall | (sclk_fall && (bit_cnt == '0));
  assign tx_din    = cs_fall ? stat_byte : next_byte;

  sbr_tx #(.W(BYTE_W)) u_tx (
    .clk_i, .rst_ni, .load_i(tx_load), .din_i(tx_din), .shift_i(sclk_fall), .bit_o(tx_bit)
  );

  assign miso_o = tx_bit & ~cs_ni;
  assign done_n = done_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase       <= PH_OP;
      hdr_idx     <= '0;
      op_rd       <= 1'b0;
      addr_q      <= '0;
      total_q     <= '0;
      done_q      <= '0;
      wb_idx      <= '0;
      wr_sr       <= '0;
      rd_word     <= '0;
      rd_pend     <= 1'b0;
      txn_err     <= 1'b0;
      err_prev    <= 1'b0;
      bus_addr_o  <= '0;
      bus_wr_o    <= 1'b0;
      bus_wdata_o <= '0;
      bus_rd_o    <= 1'b0;
      ev_cmd_o    <= 1'b0;
      ev_under_o  <= 1'b0;
      ev_over_o   <= 1'b0;
      ev_end_o    <= 1'b0;
    end else begin
      bus_wr_o   <= 1'b0;
      bus_rd_o   <= 1'b0;
      ev_cmd_o   <= 1'b0;
      ev_under_o <= 1'b0;
      ev_over_o  <= 1'b0;
      ev_end_o   <= 1'b0;
      rd_pend    <= bus_rd_o;

      if (rd_pend)       rd_word <= bus_rdata_i;
      else if (rd_shift) rd_word <= rd_word << BYTE_W;

      if (cs_fall) begin
        phase   <= PH_OP;
        hdr_idx <= '0;
        wb_idx  <= '0;
        done_q  <= '0;
        txn_err <= 1'b0;
      end else if (cs_rise) begin
        ev_under_o <= (phase == PH_HDR) || (phase == PH_DATA);
        ev_end_o   <= (bit_cnt != '0);
        err_prev   <= txn_err || (phase == PH_HDR) || (phase == PH_DATA) || (bit_cnt != '0);
        phase      <= PH_IGN;
      end else if (sclk_rise && phase == PH_DONE) begin
        ev_over_o <= 1'b1;
        txn_err   <= 1'b1;
        phase     <= PH_IGN;
      end else if (byte_done) begin
        unique case (phase)
          PH_OP: begin
            if (rx_byte == OPC_WR || rx_byte == OPC_RD) begin
              op_rd   <= (rx_byte == OPC_RD);
              hdr_idx <= 2'd1;
              phase   <= PH_HDR;
            end else begin
              ev_cmd_o <= 1'b1;
              txn_err  <= 1'b1;
              phase    <= PH_IGN;
            end
          end
          PH_HDR: begin
            hdr_idx <= hdr_idx + 1'b1;
            if (hdr_idx == 2'd1) addr_q[ADDR_W-1 -: BYTE_W] <= rx_byte;
            else if (hdr_idx == 2'd2) addr_q[BYTE_W-1:0] <= rx_byte;
            else begin
              total_q <= (rx_byte == '0) ? TOT_W'(MAX_WORDS) : TOT_W'(rx_byte);
              phase   <= PH_DATA;
              if (op_rd) begin
                bus_rd_o   <= 1'b1;
                bus_addr_o <= addr_q;
                addr_q     <= addr_q + STEP;
              end
            end
          end
          PH_DATA: begin
            wr_sr  <= {wr_sr[WORD_W-BYTE_W-1:0], rx_byte};
            wb_idx <= wb_idx + 1'b1;
            if (wb_idx == WB_W'(BPW - 1)) begin
              done_q <= done_n;
              if (!op_rd) begin
                bus_wr_o    <= 1'b1;
                bus_addr_o  <= addr_q;
                bus_wdata_o <= {wr_sr[WORD_W-BYTE_W-1:0], rx_byte};
                addr_q      <= addr_q + STEP;
              end else if (done_n < total_q) begin
                bus_rd_o   <= 1'b1;
                bus_addr_o <= addr_q;
                addr_q     <= addr_q + STEP;
              end
              if (done_n == total_q) phase <= PH_DONE;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/sbr_checks.sv
module sbr_checks (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_ni,
  input logic bus_wr_o,
  input logic bus_rd_o,
  input logic ev_cmd_o,
  input logic ev_under_o,
  input logic ev_over_o,
  input logic ev_end_o
);
  p_strobe_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({bus_wr_o, bus_rd_o}));

  p_wr_in_frame_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_wr_o |-> $past(!cs_ni));

  p_rd_in_frame_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rd_o |-> $past(!cs_ni));

  p_cmd_no_bus_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_cmd_o |-> !bus_wr_o && !bus_rd_o);

  p_under_at_cs_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_under_o |-> $past(cs_ni));

  p_over_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_over_o |=> !ev_over_o);

  p_over_no_wr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_over_o |-> !bus_wr_o);

  p_end_at_cs_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_end_o |-> $past(cs_ni));
endmodule

bind spi_burst_slave sbr_checks u_checks (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni),
  .bus_wr_o(bus_wr_o), .bus_rd_o(bus_rd_o),
  .ev_cmd_o(ev_cmd_o), .ev_under_o(ev_under_o),
  .ev_over_o(ev_over_o), .ev_end_o(ev_end_o)
);

// File: tb/tb_spi_burst_slave.sv
module tb_spi_burst_slave;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic        miso;
  logic [7:0]  stat = 8'h5C;
  logic [15:0] bus_addr;
  logic        bus_wr, bus_rd;
  logic [31:0] bus_wdata, bus_rdata = '0;
  logic        ev_cmd, ev_under, ev_over, ev_end;

  always #2 clk = ~clk;

  spi_burst_slave dut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_ni(cs_n), .mosi_i(mosi),
    .miso_o(miso), .status_i(stat), .bus_addr_o(bus_addr), .bus_wr_o(bus_wr),
    .bus_wdata_o(bus_wdata), .bus_rd_o(bus_rd), .bus_rdata_i(bus_rdata),
    .ev_cmd_o(ev_cmd), .ev_under_o(ev_under), .ev_over_o(ev_over), .ev_end_o(ev_end)
  );

  int n_chk = 0, n_fail = 0;
  int c_cmd, c_under, c_over, c_end;
  int ex_cmd, ex_under, ex_over, ex_end;
  bit prev_err = 1'b0;
  logic [7:0]  tx_q[$], rx_q[$], exp_miso[$];
  logic [15:0] exp_wa[$], exp_ra[$];
  logic [31:0] exp_wd[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rd_val(input logic [15:0] a);
    return {a ^ 16'hC3A5, ~a};
  endfunction

  // bus responder: data valid the cycle after the strobe
  always @(posedge clk) if (bus_rd) bus_rdata <= rd_val(bus_addr);

  // reference comparison on every clock
  always @(negedge clk) if (rst_n) begin
    if (bus_wr) begin
      if (exp_wa.size() == 0) chk(1'b0, "R3", "unexpected write", {16'h0, bus_addr}, 32'h0);
      else begin
        chk(bus_addr === exp_wa[0], "R3", "write address", {16'h0, bus_addr}, {16'h0, exp_wa[0]});
        chk(bus_wdata === exp_wd[0], "R3", "write data", bus_wdata, exp_wd[0]);
        void'(exp_wa.pop_front());
        void'(exp_wd.pop_front());
      end
    end
    if (bus_rd) begin
      if (exp_ra.size() == 0) chk(1'b0, "R4", "unexpected read", {16'h0, bus_addr}, 32'h0);
      else begin
        chk(bus_addr === exp_ra[0], "R4", "read address", {16'h0, bus_addr}, {16'h0, exp_ra[0]});
        void'(exp_ra.pop_front());
      end
    end
    c_cmd   += int'(ev_cmd);
    c_under += int'(ev_under);
    c_over  += int'(ev_over);
    c_end   += int'(ev_end);
  end

  task automatic predict(input int tail);
    int n, total, c;
    bit valid, rd;
    logic [15:0] base;
    logic [7:0] op;
    n = tx_q.size();
    op = (n > 0) ? tx_q[0] : 8'h00;
    valid = (n > 0) && (op == 8'h61 || op == 8'h41);
    rd = (op == 8'h41);
    total = (n >= 4) ? ((tx_q[3] == 8'h00) ? 256 : int'(tx_q[3])) : 0;
    base = (n >= 3) ? {tx_q[1], tx_q[2]} : 16'h0;
    c = (n >= 4) ? (((n - 4) / 4 < total) ? (n - 4) / 4 : total) : 0;
    exp_miso.delete();
    for (int i = 0; i < n; i++) begin
      if (i == 0) exp_miso.push_back({stat[7:4], prev_err, stat[2:0]});
      else if (valid && rd && i >= 4 && (i - 4) / 4 < total) begin
        logic [31:0] w;
        w = rd_val(base + 16'(4 * ((i - 4) / 4)));
        exp_miso.push_back(w[8 * (3 - (i - 4) % 4) +: 8]);
      end else exp_miso.push_back(8'h00);
    end
    if (valid && !rd && n >= 4)
      for (int w = 0; w < c; w++) begin
        exp_wa.push_back(base + 16'(4 * w));
        exp_wd.push_back({tx_q[4 + 4 * w], tx_q[5 + 4 * w], tx_q[6 + 4 * w], tx_q[7 + 4 * w]});
      end
    if (valid && rd && n >= 4)
      for (int w = 0; w < ((c + 1 < total) ? c + 1 : total); w++)
        exp_ra.push_back(base + 16'(4 * w));
    ex_cmd   = (n > 0 && !valid) ? 1 : 0;
    ex_over  = (valid && n >= 4 && ((n - 4 > 4 * total) || (n - 4 == 4 * total && tail > 0))) ? 1 : 0;
    ex_under = (valid && ex_over == 0 && (n < 4 || (n - 4) / 4 < total)) ? 1 : 0;
    ex_end   = (tail > 0) ? 1 : 0;
  endtask

  task automatic bit_io(input logic b, output logic r);
    mosi = b;
    repeat (4) @(negedge clk);
    r = miso;
    sclk = 1'b1;
    repeat (4) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic xfer(input int tail);
    logic rb;
    rx_q.delete();
    @(negedge clk) cs_n = 1'b0;
    repeat (4) @(negedge clk);
    foreach (tx_q[i]) begin
      logic [7:0] r;
      for (int b = 7; b >= 0; b--) begin
        bit_io(tx_q[i][b], rb);
        r[b] = rb;
      end
      rx_q.push_back(r);
    end
    for (int t = 0; t < tail; t++) bit_io(1'b1, rb);
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic run(input string tag, input int tail);
    int mism;
    logic [7:0] fa, fe;
    predict(tail);
    c_cmd = 0; c_under = 0; c_over = 0; c_end = 0;
    xfer(tail);
    mism = 0; fa = 8'h0; fe = 8'h0;
    foreach (exp_miso[i])
      if (rx_q[i] !== exp_miso[i]) begin
        if (mism == 0) begin fa = rx_q[i]; fe = exp_miso[i]; end
        mism++;
      end
    chk(mism == 0, tag, "MISO byte stream (R9)", {24'h0, fa}, {24'h0, fe});
    chk(exp_wa.size() == 0, tag, "writes missing", exp_wa.size(), 0);
    chk(exp_ra.size() == 0, tag, "reads missing", exp_ra.size(), 0);
    chk(c_cmd == ex_cmd, "R1", "invalid-command events", c_cmd, ex_cmd);
    chk(c_under == ex_under, "R6", "underflow events", c_under, ex_under);
    chk(c_over == ex_over, "R7", "overflow events", c_over, ex_over);
    chk(c_end == ex_end, "R8", "end-of-transfer events", c_end, ex_end);
    prev_err = (ex_cmd + ex_under + ex_over + ex_end) != 0;
    exp_wa.delete(); exp_wd.delete(); exp_ra.delete();
  endtask

  task automatic hdr(input logic [7:0] op, input logic [15:0] a, input logic [7:0] cnt);
    tx_q.delete();
    tx_q.push_back(op); tx_q.push_back(a[15:8]); tx_q.push_back(a[7:0]); tx_q.push_back(cnt);
  endtask

  task automatic push_word(input logic [31:0] w);
    for (int k = 3; k >= 0; k--) tx_q.push_back(w[8 * k +: 8]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    // R10 reset state
    chk({miso, bus_wr, bus_rd, ev_cmd, ev_under, ev_over, ev_end} == 7'b0, "R10",
        "outputs in reset", {25'h0, miso, bus_wr, bus_rd, ev_cmd, ev_under, ev_over, ev_end}, 32'h0);
    chk(bus_addr == 16'h0, "R10", "address in reset", {16'h0, bus_addr}, 32'h0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R3 R2 two-word write, status flag starts clear (R10, R5)
    hdr(8'h61, 16'h0100, 8'd2); push_word(32'hDEADBEEF); push_word(32'h01234567);
    run("R3", 0);
    // R4 three-word read, status bit 3 replaced (R5)
    hdr(8'h41, 16'h0200, 8'd3);
    for (int i = 0; i < 12; i++) tx_q.push_back(8'hFF);
    run("R4", 0);
    // R1 invalid opcode ignored
    hdr(8'h23, 16'h0300, 8'd1); push_word(32'hCAFEF00D);
    run("R1", 0);
    // R5 status reports previous error
    hdr(8'h61, 16'h1234, 8'd1); push_word(32'h89ABCDEF);
    run("R5", 0);
    // R6 short write keeps completed word
    hdr(8'h61, 16'h0400, 8'd3); push_word(32'h11112222);
    run("R6", 0);
    // R7 extra byte after a write burst
    hdr(8'h61, 16'h0500, 8'd1); push_word(32'h33334444); tx_q.push_back(8'h55);
    run("R7", 0);
    // R7 extra byte after a read burst returns zero
    hdr(8'h41, 16'h0600, 8'd1);
    for (int i = 0; i < 5; i++) tx_q.push_back(8'h00);
    run("R7", 0);
    // R8 chip select mid-byte inside the header
    tx_q.delete(); tx_q.push_back(8'h61); tx_q.push_back(8'h12);
    run("R8", 3);
    // R6 read stopped right after header: first word fetched
    hdr(8'h41, 16'h0700, 8'd4);
    run("R6", 0);
    // R2 count 0 means 256 words, address wraps
    hdr(8'h61, 16'hFFF0, 8'd0);
    for (int i = 0; i < 256; i++) push_word(32'hA5000000 ^ (i * 32'h01010101));
    run("R2", 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule